// File: doc/BRIEF.md
# Prioritized Interrupt Control Unit

This unit sits between a set of maskable interrupt sources and the CPU's dispatch logic. Each source owns a small control register. The register holds a two-bit priority level, a mask bit, a context-switch enable and a macro-service enable. Incoming request pulses are captured in per-source pending flags. The unmasked pending flags then compete, and the unit presents one winner to the CPU each cycle.

The winner is the eligible source with the numerically lowest priority level, where level 0 is the most urgent. When several eligible sources share that level, the one with the lowest index wins. Along with the winner's index, the unit reports how it is to be served: by macro service, by context switch, or by an ordinary vectored interrupt. Software reaches the control fields through a simple register port with per-bit write enables. When the macro-service engine drains a source's transfer counter, it sends a completion pulse, and the unit clears that source's macro-service enable by itself.

Top module: `intc_prio`

## Requirements
- R1: After reset every source reads back priority 3, masked, context switch off, macro service off and not pending (read value 6'b000111), and no winner is presented.
- R2: A request pulse on a source sets its pending flag (read bit 5) on the next clock edge. The flag stays set until that source is acknowledged as winner.
- R3: A masked source (bit 2 = 1) never wins. Its pending flag is kept, and the source can win after it is unmasked.
- R4: Among unmasked pending sources, the one whose priority field (bits 1:0) holds the lowest value wins.
- R5: Among unmasked pending sources that share the best priority level, the lowest source index wins.
- R6: The dispatch mode output is 2 when the winner's macro-service enable (bit 4) is set. It is 1 when only its context-switch enable (bit 3) is set, and 0 otherwise.
- R7: A completion pulse for a source clears its macro-service enable on the next edge. This clear overrides a software write to the same bit in the same cycle.
- R8: A write changes only the control bits whose byte-enable bit is 1, and it never changes the pending flag.
- R9: An acknowledge while a winner is valid clears only that winner's pending flag. A new request for the same source in the same cycle keeps the flag set.
- R10: Writes to addresses at or above the source count change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 21 | Per-source request pulses |
| ms_done_i | input | 21 | Per-source macro-service completion pulses |
| ack_i | input | 1 | Acknowledge of the current winner |
| addr_i | input | 5 | Register index (source number) for read and write |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 5 | Write data: [1:0] priority, [2] mask, [3] context, [4] macro |
| wbe_i | input | 5 | Per-bit write enables matching wdata_i |
| rdata_o | output | 6 | Read data of addressed register, bit 5 = pending |
| irq_valid_o | output | 1 | A winner is presented |
| irq_id_o | output | 5 | Winning source index |
| irq_mode_o | output | 2 | Dispatch mode: 0 vectored, 1 context switch, 2 macro service |

## Verification
The winner outputs are combinational from the registered state, so a corrupted flag shows at the ports in the cycle right after the edge that stored it. A lost or stuck pending bit appears as a wrong or missing winner, or as a wrong value of read bit 5. A bad priority or mask bit redirects the winner to another source. A macro-service enable that fails to clear shows up as a dispatch mode still at 2 once the completion pulse has passed. The bench reads back the addressed register every cycle, so register damage that arbitration hides still shows within one cycle.

// File: rtl/intc_prio_pkg.sv
package intc_prio_pkg;
  localparam int unsigned CTRL_W  = 5;
  localparam int unsigned PRIO_W  = 2;
  localparam int unsigned N_LVL   = 1 << PRIO_W;
  localparam int unsigned B_MASK  = 2;
  localparam int unsigned B_CTX   = 3;
  localparam int unsigned B_MAC   = 4;

  typedef enum logic [1:0] {
    MODE_VEC = 2'd0,
    MODE_CTX = 2'd1,
    MODE_MAC = 2'd2
  } disp_mode_e;

  typedef struct packed {
    logic              mac;
    logic              ctx;
    logic              mask;
    logic [PRIO_W-1:0] prio;
  } src_ctrl_t;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
  import intc_prio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [CTRL_W-1:0] wbe_i,
  input  logic              req_i,
  input  logic              clr_i,
  input  logic              ms_done_i,
  output src_ctrl_t         ctrl_o,
  output logic              pend_o
);
  src_ctrl_t ctrl_q, ctrl_d;
  logic      pend_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = src_ctrl_t'((ctrl_q & ~wbe_i) | (wdata_i & wbe_i));
    if (ms_done_i) ctrl_d.mac = 1'b0;  // hardware clear wins over write
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.prio <= '1;
      ctrl_q.mask <= 1'b1;
      ctrl_q.ctx  <= 1'b0;
      ctrl_q.mac  <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (req_i)      pend_q <= 1'b1;  // new request wins over ack
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_prio_pkg::*;
#(
  parameter int unsigned N_SRC = 21,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             elig_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [N_LVL-1:0][N_SRC-1:0] lvl_vec;
  logic [N_SRC-1:0]            cand;

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign lvl_vec[l][s] = elig_i[s] && (prio_i[s] == PRIO_W'(l));
    end
  end

  // pick the most urgent non-empty level
  always_comb begin
    cand = '0;
    for (int l = N_LVL - 1; l >= 0; l--) begin
      if (|lvl_vec[l]) cand = lvl_vec[l];
    end
  end

  // lowest index inside that level
  always_comb begin
    idx_o = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (cand[s]) idx_o = IDX_W'(s);
    end
  end

  assign valid_o = |elig_i;
endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_prio_pkg::*;
#(
  parameter int unsigned N_SRC = 21,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [IDX_W-1:0]      addr_i,
  input  logic                  wr_i,
  input  src_ctrl_t [N_SRC-1:0] ctrl_i,
  input  logic [N_SRC-1:0]      pend_i,
  output logic [N_SRC-1:0]      wsel_o,
  output logic [CTRL_W:0]       rdata_o
);
  logic in_range;

  assign in_range = ({1'b0, addr_i} < (IDX_W + 1)'(N_SRC));

  for (genvar s = 0; s < N_SRC; s++) begin : g_sel
    assign wsel_o[s] = wr_i && in_range && (addr_i == IDX_W'(s));
  end

  always_comb begin
    rdata_o = '0;
    if (in_range) rdata_o = {pend_i[addr_i], ctrl_i[addr_i]};
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio
  import intc_prio_pkg::*;
#(
  parameter int unsigned N_SRC = 21,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [N_SRC-1:0]  ms_done_i,
  input  logic              ack_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [CTRL_W-1:0] wbe_i,
  output logic [CTRL_W:0]   rdata_o,
  output logic              irq_valid_o,
  output logic [IDX_W-1:0]  irq_id_o,
  output logic [1:0]        irq_mode_o
);
  src_ctrl_t [N_SRC-1:0]             ctrl;
  logic [N_SRC-1:0]                  pend;
  logic [N_SRC-1:0]                  mask_v;
  logic [N_SRC-1:0]                  mac_v;
  logic [N_SRC-1:0][PRIO_W-1:0]      prio_v;
  logic [N_SRC-1:0]                  wsel;
  logic [N_SRC-1:0]                  clr;
  logic [N_SRC-1:0]                  elig;
  disp_mode_e                        mode;

  intc_regif #(.N_SRC(N_SRC)) u_regif (
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .ctrl_i  (ctrl),
    .pend_i  (pend),
    .wsel_o  (wsel),
    .rdata_o (rdata_o)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    intc_src_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wsel[s]),
      .wdata_i   (wdata_i),
      .wbe_i     (wbe_i),
      .req_i     (req_i[s]),
      .clr_i     (clr[s]),
      .ms_done_i (ms_done_i[s]),
      .ctrl_o    (ctrl[s]),
      .pend_o    (pend[s])
    );
    assign mask_v[s] = ctrl[s].mask;
    assign mac_v[s]  = ctrl[s].mac;
    assign prio_v[s] = ctrl[s].prio;
    assign elig[s]   = pend[s] && !ctrl[s].mask;
    assign clr[s]    = ack_i && irq_valid_o && (irq_id_o == IDX_W'(s));
  end

  intc_arb #(.N_SRC(N_SRC)) u_arb (
    .elig_i  (elig),
    .prio_i  (prio_v),
    .valid_o (irq_valid_o),
    .idx_o   (irq_id_o)
  );

  always_comb begin
    mode = MODE_VEC;
    if (ctrl[irq_id_o].mac)      mode = MODE_MAC;
    else if (ctrl[irq_id_o].ctx) mode = MODE_CTX;
  end

  assign irq_mode_o = mode;
endmodule

// File: rtl/intc_prio_chk.sv
module intc_prio_chk
  import intc_prio_pkg::*;
#(
  parameter int unsigned N_SRC = 21,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [N_SRC-1:0]             req_i,
  input logic [N_SRC-1:0]             ms_done_i,
  input logic                         ack_i,
  input logic                         irq_valid_o,
  input logic [IDX_W-1:0]             irq_id_o,
  input logic [1:0]                   irq_mode_o,
  input logic [N_SRC-1:0]             pend,
  input logic [N_SRC-1:0]             mask_v,
  input logic [N_SRC-1:0]             mac_v,
  input logic [N_SRC-1:0][PRIO_W-1:0] prio_v
);
  logic better_exists;

  always_comb begin
    better_exists = 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      if (pend[s] && !mask_v[s] && irq_valid_o &&
          (prio_v[s] < prio_v[irq_id_o] ||
           (prio_v[s] == prio_v[irq_id_o] && IDX_W'(s) < irq_id_o)))
        better_exists = 1'b1;
    end
  end

  // R3
  winner_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (pend[irq_id_o] && !mask_v[irq_id_o]));

  // R4
  best_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> !better_exists);

  // R6
  mac_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && mac_v[irq_id_o]) |-> (irq_mode_o == 2'd2));

  // R2
  req_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((pend & $past(req_i)) == $past(req_i)));

  // R7
  mac_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ms_done_i) |=> ((mac_v & $past(ms_done_i)) == '0));

  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_valid_o && !req_i[irq_id_o]) |=> !pend[$past(irq_id_o)]);
endmodule

bind intc_prio intc_prio_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ms_done_i   (ms_done_i),
  .ack_i       (ack_i),
  .irq_valid_o (irq_valid_o),
  .irq_id_o    (irq_id_o),
  .irq_mode_o  (irq_mode_o),
  .pend        (pend),
  .mask_v      (mask_v),
  .mac_v       (mac_v),
  .prio_v      (prio_v)
);

// File: tb/intc_prio_tb.sv
module intc_prio_tb;
  localparam int N = 21;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] ms_done_i = '0;
  logic         ack_i = 1'b0;
  logic [4:0]   addr_i = '0;
  logic         wr_i = 1'b0;
  logic [4:0]   wdata_i = '0;
  logic [4:0]   wbe_i = '0;
  logic [5:0]   rdata_o;
  logic         irq_valid_o;
  logic [4:0]   irq_id_o;
  logic [1:0]   irq_mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  bit [1:0] m_prio [N];
  bit [N-1:0] m_mask, m_ctx, m_mac, m_pend;

  always #10 clk_i = ~clk_i;

  intc_prio u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int s = 0; s < N; s++) m_prio[s] = 2'd3;
    m_mask = '1; m_ctx = '0; m_mac = '0; m_pend = '0;
  endfunction

  function automatic bit m_win(output int id);
    id = 0;
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < N; s++)
        if (m_pend[s] && !m_mask[s] && m_prio[s] == l) begin id = s; return 1; end
    return 0;
  endfunction

  function automatic int m_mode(input int id);
    if (m_mac[id]) return 2;
    if (m_ctx[id]) return 1;
    return 0;
  endfunction

  function automatic int m_read(input int a);
    if (a >= N) return 0;
    return {m_pend[a], m_mac[a], m_ctx[a], m_mask[a], m_prio[a]};
  endfunction

  task automatic compare(input string tag);
    int  id;
    bit  v;
    v = m_win(id);
    chk(irq_valid_o == v, tag, irq_valid_o, v);
    if (v) begin
      chk(irq_id_o == id, tag, irq_id_o, id);
      chk(irq_mode_o == m_mode(id), tag, irq_mode_o, m_mode(id));
    end
    chk(rdata_o == m_read(addr_i), tag, rdata_o, m_read(addr_i));
  endtask

  task automatic step(input string tag, input bit wr, input int a, input bit [4:0] wd,
                      input bit [4:0] be, input bit [N-1:0] rq, input bit ak,
                      input bit [N-1:0] md);
    int id;
    bit v;
    bit [4:0] cur;
    v = m_win(id);
    wr_i = wr; addr_i = 5'(a); wdata_i = wd; wbe_i = be;
    req_i = rq; ack_i = ak; ms_done_i = md;
    @(posedge clk_i);
    for (int s = 0; s < N; s++) begin
      if (wr && a == s) begin
        cur = {m_mac[s], m_ctx[s], m_mask[s], m_prio[s]};
        cur = (cur & ~be) | (wd & be);
        {m_mac[s], m_ctx[s], m_mask[s], m_prio[s]} = cur;
      end
      if (md[s]) m_mac[s] = 1'b0;
      if (rq[s]) m_pend[s] = 1'b1;
      else if (ak && v && id == s) m_pend[s] = 1'b0;
    end
    #1;
    wr_i = 0; req_i = '0; ack_i = 0; ms_done_i = '0;
    compare(tag);
  endtask

  function automatic bit [N-1:0] bitn(input int s);
    return (N)'(1) << s;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    m_reset();
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    for (int s = 0; s < N; s++) begin
      addr_i = 5'(s); #1;
      chk(rdata_o == 6'b000111, "R1", rdata_o, 6'b000111);
    end
    chk(irq_valid_o == 1'b0, "R1", irq_valid_o, 0);

    // R2/R3: request on masked source is held but cannot win
    step("R2", 0, 4, 0, 0, bitn(4), 0, '0);
    chk(rdata_o == 6'b100111 && irq_valid_o == 0, "R3", {irq_valid_o, rdata_o}, 6'b100111);
    step("R8", 1, 4, 5'b00000, 5'b00100, '0, 0, '0);  // unmask only
    chk(irq_valid_o && irq_id_o == 4 && rdata_o == 6'b100011, "R3", irq_id_o, 4);
    // R5 tie on level 3
    step("R5", 1, 2, 5'b00000, 5'b00100, '0, 0, '0);
    step("R5", 1, 9, 5'b00000, 5'b00100, bitn(2) | bitn(9), 0, '0);
    chk(irq_id_o == 2, "R5", irq_id_o, 2);
    // R4 raise priority of 9
    step("R4", 1, 9, 5'b00001, 5'b00011, '0, 0, '0);
    chk(irq_id_o == 9 && irq_mode_o == 0, "R4", irq_id_o, 9);
    // R6 modes
    step("R6", 1, 9, 5'b01000, 5'b01000, '0, 0, '0);
    chk(irq_mode_o == 1, "R6", irq_mode_o, 1);
    step("R6", 1, 9, 5'b10000, 5'b10000, '0, 0, '0);
    chk(irq_mode_o == 2, "R6", irq_mode_o, 2);
    // R7 completion clears macro enable, even against a same-cycle write
    step("R7", 0, 9, 0, 0, '0, 0, bitn(9));
    chk(irq_mode_o == 1, "R7", irq_mode_o, 1);
    step("R7", 1, 9, 5'b10000, 5'b10000, '0, 0, bitn(9));
    chk(rdata_o[4] == 0 && irq_mode_o == 1, "R7", rdata_o, 0);
    // R9 ack with same-cycle request keeps pending, plain ack clears
    step("R9", 0, 9, 0, 0, bitn(9), 1, '0);
    chk(irq_id_o == 9, "R9", irq_id_o, 9);
    step("R9", 0, 9, 0, 0, '0, 1, '0);
    chk(irq_id_o == 2 && rdata_o[5] == 0, "R9", irq_id_o, 2);
    // R10 out-of-range address
    step("R10", 1, 25, 5'b11111, 5'b11111, '0, 0, '0);
    chk(rdata_o == 0, "R10", rdata_o, 0);
    step("R10", 1, 31, 5'b00000, 5'b11111, '0, 0, '0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit [N-1:0] rq, md;
      rq = '0; md = '0;
      for (int s = 0; s < N; s++) begin
        if ($urandom_range(99) < 8) rq[s] = 1'b1;
        if ($urandom_range(99) < 3) md[s] = 1'b1;
      end
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random",
           $urandom_range(99) < 35, $urandom_range(23), 5'($urandom),
           5'($urandom), rq, $urandom_range(99) < 30, md);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule